// File: doc/BRIEF.md
# Split-Port Double-Rate Burst Memory Core

This block is an on-chip synchronous memory with one data bus for writing and a separate data bus for reading. Because the two buses never share wires, no turnaround cycles are needed between the two directions. One address bus serves both ports by time multiplexing. A fast internal clock runs at twice the access rate, and a phase bit toggles on every edge. Two fast edges make one access period. The first half of the period carries a read address and the second half carries a write address.

Every access moves a burst of two words belonging to one location, one word per half period in each direction. Word 0 of a write arrives with the write address and word 1 follows in the next half period. The pair is stored only after word 1 has been captured. Each port has its own active-low select, so a read and a write can both be issued in the same period.

The read path checks for a write whose second word is being captured on the same edge as the read address. In that case it passes the write data straight through, so a read always returns the newest data. All inputs are registered on entry and the read data leaves through an output register.

Top module: `spb_core`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0, `rdata` is all zeros and `k_phase` is 0.
- R2: After reset, `k_phase` inverts after every rising edge of `clk`. The first edge after reset is a read slot (`k_phase` was 0 before it). Edges sampled with `k_phase` at 0 take `addr` as a read address, and edges sampled with `k_phase` at 1 take it as a write address.
- R3: A read sampled at edge e puts word 0 (the low half of the stored location) on `rdata` after edge e+2 and word 1 after edge e+3. `rvalid` is 1 in both slots.
- R4: A write sampled at edge e takes word 0 from `wdata` at edge e and word 1 from `wdata` at edge e+1. A later read of that address returns both words in that order.
- R5: A read and a write issued in the same access period, to different addresses, do not disturb each other.
- R6: A read sampled on the same edge as word 1 of a write to the same address returns the two words of that write.
- R7: In output slots that belong to no read, including reads whose select was high, `rvalid` is 0 and `rdata` is all zeros.
- R8: A write slot with `wr_sel_n` high leaves the array unchanged, whatever `addr` and `wdata` carry.
- R9: A read sampled before a write to the same address (earlier edge, same period) returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each rising edge is one half access period |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled in read slots |
| wr_sel_n | input | 1 | Active-low write request, sampled in write slots |
| addr | input | ADDR_W | Shared address: read address in read slots, write address in write slots |
| wdata | input | WORD_W | Write data: word 0 in the write slot, word 1 in the following read slot |
| k_phase | output | 1 | Current half-period phase: 0 = next edge is a read slot, 1 = write slot |
| rdata | output | WORD_W | Registered read data, word 0 then word 1 |
| rvalid | output | 1 | High in each slot that carries a read word |

## Verification
The first pattern is a fill followed by plain readback. It separates a correct storage order of word 0 and word 1 from a swapped one, and it exposes a wrong output latency.

Next come periods that mix reads with writes to other addresses. Directed pairs then aim a read at the address whose write is still completing, both on the word-1 edge and one edge earlier. These show whether forwarding is present and whether it is placed on the right edge. Deselected write slots that carry live data and address show whether the write select is obeyed. A long run of random back-to-back reads and writes over a small address set checks that `rvalid` stays continuous and that idle slots return to zero.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic {
        PH_RD = 1'b0,
        PH_WR = 1'b1
    } kphase_e;

    localparam int unsigned BURST_LEN = 2;
endpackage

// File: rtl/spb_capture.sv
module spb_capture
    import spb_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output kphase_e       phase_o,
    output logic          cap_rd,
    output logic          cap_wr,
    output kphase_e       cap_ph,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);
    typedef struct packed {
        kphase_e       ph;
        logic          rd;
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } cap_t;

    typedef struct packed {
        kphase_e phase;
        cap_t    cap;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.phase    = (s_q.phase == PH_RD) ? PH_WR : PH_RD;
        s_d.cap.ph   = s_q.phase;
        s_d.cap.rd   = !rd_sel_n && (s_q.phase == PH_RD);
        s_d.cap.wr   = !wr_sel_n && (s_q.phase == PH_WR);
        s_d.cap.a    = addr;
        s_d.cap.d    = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = s_q.phase;
    assign cap_rd   = s_q.cap.rd;
    assign cap_wr   = s_q.cap.wr;
    assign cap_ph   = s_q.cap.ph;
    assign cap_addr = s_q.cap.a;
    assign cap_data = s_q.cap.d;
endmodule

// File: rtl/spb_wstage.sv
module spb_wstage
    import spb_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 18,
    localparam int unsigned LW = DW * BURST_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_wr,
    input  kphase_e       cap_ph,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    output logic          commit,
    output logic [AW-1:0] waddr,
    output logic [LW-1:0] wline
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] a;
        logic [DW-1:0] w0;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        commit = 1'b0;
        if (cap_wr) begin
            s_d.pend = 1'b1;
            s_d.a    = cap_addr;
            s_d.w0   = cap_data;
        end else if (s_q.pend && cap_ph == PH_RD) begin
            commit   = 1'b1;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign waddr = s_q.a;
    assign wline = {cap_data, s_q.w0};
endmodule

// File: rtl/spb_array.sv
module spb_array
    import spb_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 18,
    localparam int unsigned LW    = DW * BURST_LEN,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wline,
    input  logic [AW-1:0] raddr,
    output logic [LW-1:0] rline
);
    logic hit;
    assign hit = we && (waddr == raddr);

    for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
        logic [DW-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                bank[waddr] <= wline[b*DW +: DW];
            end
        end

        assign rline[b*DW +: DW] = hit ? wline[b*DW +: DW] : bank[raddr];
    end
endmodule

// File: rtl/spb_rdout.sv
module spb_rdout
    import spb_pkg::*;
#(
    parameter int unsigned DW = 18,
    localparam int unsigned LW = DW * BURST_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_rd,
    input  logic [LW-1:0] rline,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic          line_v;
        logic [LW-1:0] line;
        logic          hold_v;
        logic [DW-1:0] hold;
        logic          out_v;
        logic [DW-1:0] out;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.line_v = cap_rd;
        s_d.line   = cap_rd ? rline : s_q.line;
        s_d.hold_v = 1'b0;
        if (s_q.line_v) begin
            s_d.out_v  = 1'b1;
            s_d.out    = s_q.line[DW-1:0];
            s_d.hold_v = 1'b1;
            s_d.hold   = s_q.line[LW-1:DW];
        end else if (s_q.hold_v) begin
            s_d.out_v = 1'b1;
            s_d.out   = s_q.hold;
        end else begin
            s_d.out_v = 1'b0;
            s_d.out   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = s_q.out;
    assign rvalid = s_q.out_v;
endmodule

// File: rtl/spb_core.sv
module spb_core
    import spb_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned WORD_W = 18,
    localparam int unsigned LINE_W = WORD_W * BURST_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              k_phase,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    kphase_e             phase;
    logic                cap_rd;
    logic                cap_wr;
    kphase_e             cap_ph;
    logic [ADDR_W-1:0]   cap_addr;
    logic [WORD_W-1:0]   cap_data;
    logic                commit;
    logic [ADDR_W-1:0]   waddr;
    logic [LINE_W-1:0]   wline;
    logic [LINE_W-1:0]   rline;

    spb_capture #(.AW(ADDR_W), .DW(WORD_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .phase_o  (phase),
        .cap_rd   (cap_rd),
        .cap_wr   (cap_wr),
        .cap_ph   (cap_ph),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    spb_wstage #(.AW(ADDR_W), .DW(WORD_W)) u_wstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_wr   (cap_wr),
        .cap_ph   (cap_ph),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .commit   (commit),
        .waddr    (waddr),
        .wline    (wline)
    );

    spb_array #(.AW(ADDR_W), .DW(WORD_W)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (waddr),
        .wline (wline),
        .raddr (cap_addr),
        .rline (rline)
    );

    spb_rdout #(.DW(WORD_W)) u_rdout (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_rd (cap_rd),
        .rline  (rline),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    assign k_phase = (phase == PH_WR);
endmodule

// File: rtl/spb_core_chk.sv
module spb_core_chk #(
    parameter int unsigned WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_sel_n,
    input logic              k_phase,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid
);
    // R1: quiet outputs while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!rvalid && rdata == '0 && !k_phase)
                else $error("reset outputs not idle");
        end
    end

    // R2: phase alternates every edge
    p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (k_phase != $past(k_phase)));

    // R3: selected read gives two valid slots after the fixed latency
    p_read_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_phase && !rd_sel_n) |-> ##3 rvalid ##1 rvalid);

    // R3: a burst always starts in the slot that holds word 0
    p_burst_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> k_phase);

    // R7: deselected read leaves its two output slots empty
    p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_phase && rd_sel_n) |-> ##3 !rvalid ##1 !rvalid);

    // R7: empty slots carry zero data
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));
endmodule

bind spb_core spb_core_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .k_phase  (k_phase),
    .rdata    (rdata),
    .rvalid   (rvalid)
);

// File: tb/spb_core_test.sv
module spb_core_test;
    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          k_phase;
    logic [DW-1:0] rdata;
    logic          rvalid;

    // 250 MHz: period of 4 time units
    always #2 clk = ~clk;

    spb_core #(.ADDR_W(AW), .WORD_W(DW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .k_phase  (k_phase),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    int total = 0;
    int bad = 0;
    int edge_n = 0;
    bit done = 0;

    // reference model state
    logic [2*DW-1:0] mm [int];
    bit              ev [int];
    logic [DW-1:0]   ed [int];
    string           et [int];
    string           cur_tag = "R3";
    bit              wpend = 0;
    int              wa_m = 0;
    logic [DW-1:0]   w0_m = '0;
    logic [DW-1:0]   pend_w1 = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (edge_n % 2 == 0) begin
                if (wpend) begin
                    mm[wa_m] = {wdata, w0_m};
                    wpend = 0;
                end
                if (!rd_sel_n) begin
                    logic [2*DW-1:0] line;
                    line = mm.exists(int'(addr)) ? mm[int'(addr)] : 'x;
                    ev[edge_n+2] = 1; ed[edge_n+2] = line[DW-1:0];    et[edge_n+2] = cur_tag;
                    ev[edge_n+3] = 1; ed[edge_n+3] = line[2*DW-1:DW]; et[edge_n+3] = cur_tag;
                end
            end else if (!wr_sel_n) begin
                wpend = 1;
                wa_m  = int'(addr);
                w0_m  = wdata;
            end
            edge_n++;
        end
    end

    task automatic check_slot();
        int            e;
        bit            xv;
        logic [DW-1:0] xd;
        string         tg;
        e  = edge_n - 1;
        xv = ev.exists(e) ? ev[e] : 1'b0;
        xd = xv ? ed[e] : '0;
        tg = xv ? et[e] : "R7";
        total++;
        if (rvalid !== xv || rdata !== xd) begin
            bad++;
            $display("FAIL %s edge %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tg, e, rvalid, rdata, xv, xd);
        end
        total++;
        if (k_phase !== 1'(edge_n % 2)) begin
            bad++;
            $display("FAIL R2 edge %0d: k_phase=%0b expected %0b", e, k_phase, 1'(edge_n % 2));
        end
    endtask

    task automatic slot(bit rs_n, bit ws_n, int a, logic [DW-1:0] d);
        rd_sel_n = rs_n;
        wr_sel_n = ws_n;
        addr     = AW'(a);
        wdata    = d;
        @(negedge clk);
        check_slot();
    endtask

    task automatic kcycle(bit rd, int ra, bit wr, int wa, logic [DW-1:0] d0,
                          logic [DW-1:0] d1, string tag);
        cur_tag = tag;
        slot(!rd, 1'b1, ra, pend_w1);
        slot(1'b1, !wr, wa, d0);
        pend_w1 = d1;
    endtask

    function automatic logic [DW-1:0] pat(int a, int k);
        return DW'(a * 37 + k * 1021 + 5);
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        total++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            bad++;
            $display("FAIL R1: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end
        total++;
        if (k_phase !== 1'b0) begin
            bad++;
            $display("FAIL R1: k_phase=%0b expected 0", k_phase);
        end
        rst_n = 1'b1;

        // R4: fill, then read back in order
        for (int a = 0; a < 32; a++) kcycle(0, 0, 1, a, pat(a, 0), pat(a, 1), "R4");
        for (int a = 0; a < 16; a++) kcycle(1, a, 0, 0, '0, '0, "R4");

        // R5: reads and writes to other addresses in the same period
        for (int a = 0; a < 16; a++) kcycle(1, a, 1, 16 + a, pat(a, 2), pat(a, 3), "R5");
        for (int a = 16; a < 32; a++) kcycle(1, a, 0, 0, '0, '0, "R5");

        // R6: read on the word-1 edge of a write to the same address
        kcycle(0, 0, 1, 5, 18'h2AAAA, 18'h15555, "R6");
        kcycle(1, 5, 0, 0, '0, '0, "R6");

        // R9: read issued before a write to the same address in one period
        kcycle(1, 6, 1, 6, 18'h0F0F0, 18'h30303, "R9");
        kcycle(1, 6, 0, 0, '0, '0, "R6");

        // R8: deselected write with live address and data
        kcycle(0, 0, 0, 7, 18'h3FFFF, 18'h11111, "R8");
        kcycle(1, 7, 0, 0, '0, '0, "R8");

        // R7: reads deselected with changing addresses
        for (int i = 0; i < 3; i++) kcycle(0, i, 0, 0, '0, '0, "R7");

        // R3: random back-to-back traffic
        for (int i = 0; i < 300; i++) begin
            kcycle(($urandom % 4) != 0, $urandom % 32, $urandom % 2, $urandom % 32,
                   DW'($urandom), DW'($urandom), "R3");
        end

        for (int i = 0; i < 4; i++) kcycle(0, 0, 0, 0, '0, '0, "R7");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule